// File: doc/BRIEF.md
# Aliasing VIPT Instruction-Cache Tag Store with Line Invalidate

This block holds the tags of a two-way, set-associative instruction cache that is indexed with virtual address bits and tagged with physical page numbers. A lookup port takes the virtual and physical address of a fetch and, one cycle later, reports whether a way holds that line and which way it is. A fill port installs a tag into a chosen way. Data storage, refill sequencing and address translation sit outside the block.

When a way is larger than a page, some set-index bits lie above the page offset. Those bits may differ between a virtual address and its physical address, so one physical line can sit in several sets (aliases). A maintenance write that carries only a physical address therefore cannot pick the set by itself. The block offers two ways to supply the missing virtual index bits, chosen by a strap input. In packed mode the bits travel in the low, otherwise unused, line-offset bits of the invalidate word. In split mode a tag register is written first and a following invalidate write carries the virtual address. In both modes a line is cleared only when its stored physical tag matches.

The cache size, page size and line size are parameters. The way-to-page size ratio must be 1, 2 or 4, giving 1, 2 or 4 aliases; any other value stops elaboration.

Top module: `vipt_icache_tag_inv`

## Requirements
- R1: After reset no line is valid: every lookup misses, and `rsp_valid` is 0 until a lookup is accepted.
- R2: An accepted lookup gives `rsp_valid`=1 on the next cycle. `rsp_hit` is 1 when a way of set `lk_vaddr[PAGE_BITS+ALIAS_BITS-1:LINE_BITS]` is valid and holds tag `lk_paddr[ADDR_W-1:PAGE_BITS]`. `rsp_way` is the lowest matching way, and 0 on a miss. `rsp_valid` is 0 in every cycle that follows no accepted lookup.
- R3: An accepted fill marks way `fill_way` of set `fill_vaddr[PAGE_BITS+ALIAS_BITS-1:LINE_BITS]` valid with tag `fill_paddr[ADDR_W-1:PAGE_BITS]`.
- R4: The set is chosen by virtual bits. With the default 32 KB cache and 8 KB pages, two virtual addresses that differ only in bit 13 select different sets for the same physical line.
- R5: With `cfg_split`=0, an invalidate write takes its tag from `inv_wdata[ADDR_W-1:PAGE_BITS]`. Its set is `{inv_wdata[ALIAS_BITS-1:0], inv_wdata[PAGE_BITS-1:LINE_BITS]}`, so `inv_wdata[0]` stands for virtual bit 13 by default. Bits `[LINE_BITS-1:ALIAS_BITS]` are ignored.
- R6: With `cfg_split`=1, `ptag_we` loads a tag register from `ptag_wdata[ADDR_W-1:PAGE_BITS]` and ignores bits below `PAGE_BITS`. An invalidate write takes its set from `inv_wdata[PAGE_BITS+ALIAS_BITS-1:LINE_BITS]` and its tag from that register. When `ptag_we` and `inv_we` are high in the same cycle, the tag being written is the one used.
- R7: An invalidate clears every way of the selected set whose stored tag matches. It leaves non-matching ways and other sets unchanged.
- R8: When operations are issued in the same cycle, an invalidate wins over a fill, and a fill wins over a lookup. A losing fill changes nothing. A losing lookup produces no response.
- R9: An invalidate takes effect in one cycle: a lookup accepted in the next cycle already sees the line as cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_split | input | 1 | 0: packed alias bits in the invalidate word; 1: separate tag register |
| lk_en | input | 1 | Lookup request |
| lk_vaddr | input | ADDR_W | Lookup virtual address (selects the set) |
| lk_paddr | input | ADDR_W | Lookup physical address (gives the tag) |
| fill_en | input | 1 | Install a tag |
| fill_vaddr | input | ADDR_W | Fill virtual address |
| fill_paddr | input | ADDR_W | Fill physical address |
| fill_way | input | WAY_W | Way to write |
| ptag_we | input | 1 | Tag register write (split mode) |
| ptag_wdata | input | ADDR_W | Physical address for the tag register |
| inv_we | input | 1 | Line-invalidate write |
| inv_wdata | input | ADDR_W | Invalidate word |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Way that hit, 0 on miss |

## Verification
The bound checker watches the response port on every cycle. It checks that a response follows exactly the accepted lookups, that an invalidate or fill in the same cycle suppresses the response, and that a miss reports way 0. Whether the correct set and tag were chosen can only be seen in the bench's scenarios. Those scenarios fill aliased sets, decode packed alias bits and junk offset bits, use the split tag register with and without a same-cycle write, and clear both ways of a set at once. A randomized phase compares every response with a behavioural model.

// File: rtl/vipt_inv_pkg.sv
package vipt_inv_pkg;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_INV,
        OP_FILL,
        OP_LOOK
    } vipt_op_e;

endpackage

// File: rtl/vipt_tag_way.sv
module vipt_tag_way #(
    parameter int SET_W = 9,
    parameter int TAG_W = 19,
    localparam int SETS = 1 << SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_en,
    input  logic [SET_W-1:0] clr_set,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic [SET_W-1:0] rd_set,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_match
);

    typedef struct packed {
        logic [SETS-1:0] valid;
    } way_state_t;

    way_state_t       st_d, st_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_comb begin
        st_d = st_q;
        if (clr_en && st_q.valid[clr_set] && (tag_q[clr_set] == clr_tag)) begin
            st_d.valid[clr_set] = 1'b0;
        end
        if (wr_en) begin
            st_d.valid[wr_set] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set] <= wr_tag;
        end
    end

    assign rd_match = st_q.valid[rd_set] && (tag_q[rd_set] == rd_tag);

endmodule

// File: rtl/vipt_inv_decode.sv
module vipt_inv_decode #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BITS  = 13,
    parameter int LINE_BITS  = 5,
    parameter int ALIAS_BITS = 1,
    localparam int SET_W     = PAGE_BITS + ALIAS_BITS - LINE_BITS,
    localparam int TAG_W     = ADDR_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_split,
    input  logic              ptag_we,
    input  logic [ADDR_W-1:0] ptag_wdata,
    input  logic [ADDR_W-1:0] inv_wdata,
    output logic [SET_W-1:0]  inv_set,
    output logic [TAG_W-1:0]  inv_tag
);

    typedef struct packed {
        logic [TAG_W-1:0] ptag;
    } dec_state_t;

    dec_state_t       st_d, st_q;
    logic [TAG_W-1:0] wr_tag;
    logic [SET_W-1:0] packed_set;
    logic [SET_W-1:0] split_set;

    assign wr_tag    = ptag_wdata[ADDR_W-1:PAGE_BITS];
    assign split_set = inv_wdata[PAGE_BITS+ALIAS_BITS-1:LINE_BITS];

    generate
        if (ALIAS_BITS > 0) begin : g_packed_alias
            assign packed_set = {inv_wdata[ALIAS_BITS-1:0], inv_wdata[PAGE_BITS-1:LINE_BITS]};
        end else begin : g_packed_plain
            assign packed_set = inv_wdata[PAGE_BITS-1:LINE_BITS];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (ptag_we) begin
            st_d.ptag = wr_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (cfg_split) begin
            inv_set = split_set;
            inv_tag = st_d.ptag;
        end else begin
            inv_set = packed_set;
            inv_tag = inv_wdata[ADDR_W-1:PAGE_BITS];
        end
    end

endmodule

// File: rtl/vipt_icache_tag_inv.sv
module vipt_icache_tag_inv
    import vipt_inv_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CACHE_KB  = 32,
    parameter int WAYS      = 2,
    parameter int PAGE_BITS = 13,
    parameter int LINE_BITS = 5,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_split,
    input  logic              lk_en,
    input  logic [ADDR_W-1:0] lk_vaddr,
    input  logic [ADDR_W-1:0] lk_paddr,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_vaddr,
    input  logic [ADDR_W-1:0] fill_paddr,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic              ptag_we,
    input  logic [ADDR_W-1:0] ptag_wdata,
    input  logic              inv_we,
    input  logic [ADDR_W-1:0] inv_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way
);

    localparam int WAY_BYTES  = (CACHE_KB * 1024) / WAYS;
    localparam int PAGE_BYTES = 1 << PAGE_BITS;
    localparam int RATIO      = WAY_BYTES / PAGE_BYTES;
    localparam int ALIAS_BITS = (RATIO > 1) ? $clog2(RATIO) : 0;
    localparam int SET_W      = PAGE_BITS + ALIAS_BITS - LINE_BITS;
    localparam int TAG_W      = ADDR_W - PAGE_BITS;
    localparam int IDX_TOP    = PAGE_BITS + ALIAS_BITS;

    generate
        if (!((RATIO == 1) || (RATIO == 2) || (RATIO == 4)) || ((WAY_BYTES % PAGE_BYTES) != 0)) begin : g_bad_geometry
            $error("vipt_icache_tag_inv: way size to page size ratio must be 1, 2 or 4");
        end
    endgenerate

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [WAY_W-1:0] way;
    } rsp_state_t;

    rsp_state_t       st_d, st_q;
    vipt_op_e         op;
    logic [SET_W-1:0] lk_set, fill_set, inv_set;
    logic [TAG_W-1:0] lk_tag, fill_tag, inv_tag;
    logic [WAYS-1:0]  match;
    logic [WAY_W-1:0] match_way;

    always_comb begin
        if (inv_we)       op = OP_INV;
        else if (fill_en) op = OP_FILL;
        else if (lk_en)   op = OP_LOOK;
        else              op = OP_IDLE;
    end

    assign lk_set   = lk_vaddr[IDX_TOP-1:LINE_BITS];
    assign lk_tag   = lk_paddr[ADDR_W-1:PAGE_BITS];
    assign fill_set = fill_vaddr[IDX_TOP-1:LINE_BITS];
    assign fill_tag = fill_paddr[ADDR_W-1:PAGE_BITS];

    vipt_inv_decode #(
        .ADDR_W     (ADDR_W),
        .PAGE_BITS  (PAGE_BITS),
        .LINE_BITS  (LINE_BITS),
        .ALIAS_BITS (ALIAS_BITS)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_split  (cfg_split),
        .ptag_we    (ptag_we),
        .ptag_wdata (ptag_wdata),
        .inv_wdata  (inv_wdata),
        .inv_set    (inv_set),
        .inv_tag    (inv_tag)
    );

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            vipt_tag_way #(
                .SET_W (SET_W),
                .TAG_W (TAG_W)
            ) u_way (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    ((op == OP_FILL) && (fill_way == WAY_W'(w))),
                .wr_set   (fill_set),
                .wr_tag   (fill_tag),
                .clr_en   (op == OP_INV),
                .clr_set  (inv_set),
                .clr_tag  (inv_tag),
                .rd_set   (lk_set),
                .rd_tag   (lk_tag),
                .rd_match (match[w])
            );
        end
    endgenerate

    always_comb begin
        match_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                match_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        st_d       = '0;
        st_d.valid = (op == OP_LOOK);
        st_d.hit   = (op == OP_LOOK) && (|match);
        st_d.way   = st_d.hit ? match_way : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_hit   = st_q.hit;
    assign rsp_way   = st_q.way;

endmodule

// File: rtl/vipt_icache_tag_inv_chk.sv
module vipt_icache_tag_inv_chk #(
    parameter int WAY_W = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_en,
    input logic             fill_en,
    input logic             inv_we,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WAY_W-1:0] rsp_way
);

    // R8: an invalidate suppresses the response of a same-cycle lookup
    a_r8_inv_blocks_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        inv_we |=> !rsp_valid);

    // R8: a fill suppresses the response of a same-cycle lookup
    a_r8_fill_blocks_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> !rsp_valid);

    // R2: an unopposed lookup is answered on the next cycle
    a_r2_lookup_answered: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && !fill_en && !inv_we) |=> rsp_valid);

    // R2: a response only follows a lookup request
    a_r2_rsp_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_en));

    // R2: a hit is only flagged on a response
    a_r2_hit_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R2: a miss reports way zero
    a_r2_miss_way_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_way == '0));

endmodule

bind vipt_icache_tag_inv vipt_icache_tag_inv_chk #(.WAY_W(WAY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_en     (lk_en),
    .fill_en   (fill_en),
    .inv_we    (inv_we),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_way   (rsp_way)
);

// File: tb/vipt_icache_tag_inv_test.sv
module vipt_icache_tag_inv_test;

    localparam int NSETS = 512;   // 32 KB, 2 ways, 8 KB pages, 32 B lines

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_split = 1'b0;
    logic        lk_en = 1'b0;
    logic [31:0] lk_vaddr = '0, lk_paddr = '0;
    logic        fill_en = 1'b0;
    logic [31:0] fill_vaddr = '0, fill_paddr = '0;
    logic [0:0]  fill_way = '0;
    logic        ptag_we = 1'b0;
    logic [31:0] ptag_wdata = '0;
    logic        inv_we = 1'b0;
    logic [31:0] inv_wdata = '0;
    logic        rsp_valid, rsp_hit;
    logic [0:0]  rsp_way;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit          mv [2][NSETS];
    int unsigned mt [2][NSETS];
    int unsigned mptag = 0;
    bit          e_valid, e_hit;
    int          e_way;

    always #5 clk = ~clk;

    vipt_icache_tag_inv uut (
        .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split),
        .lk_en(lk_en), .lk_vaddr(lk_vaddr), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_paddr(fill_paddr), .fill_way(fill_way),
        .ptag_we(ptag_we), .ptag_wdata(ptag_wdata),
        .inv_we(inv_we), .inv_wdata(inv_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way)
    );

    function automatic int vset(input logic [31:0] v);
        return int'((v >> 5) % NSETS);
    endfunction

    function automatic int unsigned ptag_of(input logic [31:0] p);
        return p >> 13;
    endfunction

    // One cycle: update the model from the driven inputs, clock, compare.
    task automatic step(input string req);
        int unsigned t_new;
        int s;
        int unsigned t;
        t_new = ptag_we ? ptag_of(ptag_wdata) : mptag;
        e_valid = lk_en && !inv_we && !fill_en;
        e_hit = 0;
        e_way = 0;
        if (e_valid) begin
            s = vset(lk_vaddr);
            for (int w = 1; w >= 0; w--) begin
                if (mv[w][s] && mt[w][s] == ptag_of(lk_paddr)) begin
                    e_hit = 1;
                    e_way = w;
                end
            end
        end
        if (inv_we) begin
            if (cfg_split) begin
                s = vset(inv_wdata);
                t = t_new;
            end else begin
                s = int'(((inv_wdata & 32'h1) << 8) | ((inv_wdata >> 5) & 32'hFF));
                t = ptag_of(inv_wdata);
            end
            for (int w = 0; w < 2; w++) begin
                if (mv[w][s] && mt[w][s] == t) mv[w][s] = 0;
            end
        end else if (fill_en) begin
            s = vset(fill_vaddr);
            mv[fill_way][s] = 1;
            mt[fill_way][s] = ptag_of(fill_paddr);
        end
        mptag = t_new;
        @(posedge clk);
        @(negedge clk);
        lk_en = 0; fill_en = 0; ptag_we = 0; inv_we = 0;
        checks++;
        if (rsp_valid !== e_valid || (e_valid && (rsp_hit !== e_hit || int'(rsp_way) != e_way))) begin
            failures++;
            $display("FAIL %s: got valid=%0b hit=%0b way=%0d expected valid=%0b hit=%0b way=%0d",
                     req, rsp_valid, rsp_hit, rsp_way, e_valid, e_hit, e_way);
        end
    endtask

    task automatic do_fill(input logic [31:0] v, input logic [31:0] p, input int w, input string req);
        fill_en = 1; fill_vaddr = v; fill_paddr = p; fill_way = 1'(w);
        step(req);
    endtask

    // Lookup plus a literal expectation written from the requirements.
    task automatic do_look(input logic [31:0] v, input logic [31:0] p, input bit xh, input int xw, input string req);
        lk_en = 1; lk_vaddr = v; lk_paddr = p;
        step(req);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== xh || int'(rsp_way) != xw) begin
            failures++;
            $display("FAIL %s: got valid=%0b hit=%0b way=%0d expected valid=1 hit=%0b way=%0d",
                     req, rsp_valid, rsp_hit, rsp_way, xh, xw);
        end
    endtask

    task automatic do_inv(input logic [31:0] wd, input string req);
        inv_we = 1; inv_wdata = wd;
        step(req);
    endtask

    localparam logic [31:0] VA = 32'h0000_2040;   // bit 13 = 1
    localparam logic [31:0] VB = 32'h0000_0040;   // alias of VA, bit 13 = 0
    localparam logic [31:0] P1 = 32'h1234_6040;
    localparam logic [31:0] P2 = 32'h0ABC_E040;
    localparam logic [31:0] P3 = 32'h7777_0040;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < NSETS; s++) mv[w][s] = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1: got rsp_valid=%0b expected 0 in reset", rsp_valid);
        end
        rst_n = 1;
        @(negedge clk);
        step("R1 idle");
        do_look(VA, P1, 0, 0, "R1 empty lookup");

        // fills and aliasing
        do_fill(VA, P1, 0, "R3 fill");
        do_look(VA, P1, 1, 0, "R3 hit after fill");
        do_look(VB, P1, 0, 0, "R4 alias set empty");
        do_fill(VB, P1, 1, "R4 fill alias");
        do_look(VB, P1, 1, 1, "R4 alias hit way1");
        do_look(VA, P1, 1, 0, "R4 original still way0");
        do_fill(VA, P2, 1, "R3 second way");
        do_look(VA, P2, 1, 1, "R2 hit way1");
        do_look(VA, P3, 0, 0, "R2 tag miss");

        // packed mode
        do_inv(P1 & 32'hFFFF_FFE0, "R5 packed alias 0");
        do_look(VB, P1, 0, 0, "R9 alias line cleared");
        do_look(VA, P1, 1, 0, "R7 other set untouched");
        do_inv((P1 & 32'hFFFF_FFE0) | 32'h1F, "R5 alias 1 junk bits");
        do_look(VA, P1, 0, 0, "R5 cleared way0");
        do_look(VA, P2, 1, 1, "R7 non-matching way kept");
        do_inv((P3 & 32'hFFFF_FFE0) | 32'h1, "R7 no tag match");
        do_look(VA, P2, 1, 1, "R7 no effect");

        // split mode
        cfg_split = 1;
        do_fill(VA, P1, 0, "R3 refill");
        ptag_we = 1; ptag_wdata = P1 | 32'h1FFF;
        step("R6 tag write");
        do_look(VA, P1, 1, 0, "R6 tag write alone clears nothing");
        do_inv(VA, "R6 split invalidate");
        do_look(VA, P1, 0, 0, "R6 cleared");
        do_look(VA, P2, 1, 1, "R6 way1 kept");
        do_fill(VB, P2, 0, "R3 fill for bypass");
        ptag_we = 1; ptag_wdata = P2;
        do_inv(VB, "R6 same-cycle tag write");
        do_look(VB, P2, 0, 0, "R6 bypass cleared");

        // both ways hold the same tag
        do_fill(32'h0000_3FE0, P3, 0, "R3 dup way0");
        do_fill(32'h0000_3FE0, P3, 1, "R3 dup way1");
        do_look(32'h0000_3FE0, P3, 1, 0, "R2 lowest way");
        ptag_we = 1; ptag_wdata = P3;
        step("R6 tag write");
        do_inv(32'h0000_3FE0, "R7 both ways");
        do_look(32'h0000_3FE0, P3, 0, 0, "R7 both cleared");

        // priority
        inv_we = 1; inv_wdata = 32'h0000_0100; fill_en = 1; fill_vaddr = 32'h0000_0100;
        fill_paddr = P1; fill_way = 0; lk_en = 1; lk_vaddr = 32'h0000_0100; lk_paddr = P1;
        step("R8 inv wins");
        do_look(32'h0000_0100, P1, 0, 0, "R8 dropped fill");
        fill_en = 1; fill_vaddr = 32'h0000_0100; fill_paddr = P1; fill_way = 1;
        lk_en = 1; lk_vaddr = 32'h0000_0100; lk_paddr = P1;
        step("R8 fill wins");
        do_look(32'h0000_0100, P1, 1, 1, "R8 fill applied");

        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] va, pa;
            va = {18'h0, 1'($urandom), 3'($urandom % 3), 10'h0} | (32'($urandom % 4) << 5);
            pa = ({$urandom % 3, 13'h0}) | (va & 32'h1FFF);
            cfg_split = 1'($urandom);
            lk_en = 1'($urandom); lk_vaddr = va; lk_paddr = pa;
            fill_en = ($urandom % 4) == 0; fill_vaddr = va; fill_paddr = pa; fill_way = 1'($urandom);
            ptag_we = ($urandom % 4) == 0; ptag_wdata = pa | 32'($urandom % 8192);
            inv_we = ($urandom % 6) == 0;
            inv_wdata = cfg_split ? va : ((pa & 32'hFFFF_FFE0) | 32'(va[13]) | 32'($urandom % 16) << 1);
            step("R2 R3 R7 R8 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule